// File: doc/BRIEF.md
# Keypad Interrupt Input Controller

This block watches four column inputs of a 4 x n key matrix. Software scans the rows. Each column has two programmable settings: the level that counts as a key press (high or low), and a mask bit that takes the column out of event detection.

When an unmasked column stays at its active level for a fixed persistence time, its event flag is set. The default persistence time is 24 clock periods. Any flag that is set and unmasked raises the interrupt request.

A wake output tells the power manager that a key event is pending or happening. Part of this output is combinational on the raw pins, so it still works while the block's clock is stopped.

A small register port gives access to two bytes. The control byte holds the level and mask bits. The status byte holds the flags and the wake enable. Reading the status byte clears the flags.

Top module: `kbd_wake_ctrl`

## Requirements
- R1: After reset, the control byte reads 0x0F (all levels 0, all masks 1), the status byte reads 0x00, and irq and wake are 0.
- R2: Address 0 is the control byte: bits 7:4 are the level bits for columns 3..0 and bits 3:0 are the mask bits for columns 3..0. A write to address 0 reads back unchanged.
- R3: A level bit of 1 makes a high input active. A level bit of 0 makes a low input active.
- R4: An unmasked column that is active for 24 consecutive clock cycles sets its flag. A column that is active for only 23 cycles does not. Columns pass through a two-stage synchronizer, so the flag reads as set 26 rising edges after the input changes.
- R5: If the input leaves its active level before the count completes, the persistence count restarts from zero.
- R6: While a column's mask bit is 1, that column never sets its flag and never drives irq.
- R7: irq is the OR of all flags whose mask bit is 0. Masking a column that already has a flag set drops irq, but the flag stays set.
- R8: Address 1 is the status byte: bits 3:0 are the flags and bit 4 is the wake enable. Reading address 1 (rd_en high) clears all flags on that clock edge. A write to address 1 changes only bit 4.
- R9: A column that stays active after its flag was set and then cleared does not set the flag again. It must leave its active level and come back first.
- R10: wake is 1 when the wake enable is 1 and either irq is 1 or some unmasked raw input is at its active level. The raw-input path needs no clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| key_in | input | 4 | Keypad column inputs |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe (a status read clears the flags) |
| addr | input | 1 | 0 = control byte, 1 = status byte |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data for the byte selected by addr |
| irq | output | 1 | Interrupt request |
| wake | output | 1 | Wake request to the power manager |

## Verification
The assertions check the following on every cycle:
- a filter fire comes only from an input that was active on the cycle before;
- a column cannot fire twice in a row without re-arming;
- a masked column never raises a flag;
- a status read with no concurrent fire leaves the flags empty;
- wake never rises without its enable.

The following can only be shown by the bench's scenarios:
- the exact 23/24-cycle boundary;
- the restart after a glitch;
- the need to leave the active level before a flag can be set again;
- the clock-free wake path on the raw pins.

// File: rtl/kbd_pkg.sv
package kbd_pkg;
  localparam int unsigned NKEYS = 4;
  localparam logic ADDR_CTRL = 1'b0;
  localparam logic ADDR_STAT = 1'b1;
  localparam int unsigned WAKE_BIT = 4;
endpackage

// File: rtl/kbd_sync.sv
module kbd_sync #(
  parameter int unsigned WIDTH  = 4,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d_in,
  input  logic [WIDTH-1:0] rst_val,
  output logic [WIDTH-1:0] d_out
);
  logic [WIDTH-1:0] stage_q [STAGES];

  genvar s;
  generate
    for (s = 0; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stage_q[s] <= rst_val;
        else if (s == 0) stage_q[s] <= d_in;
        else stage_q[s] <= stage_q[(s == 0) ? 0 : s-1];
      end
    end
  endgenerate

  assign d_out = stage_q[STAGES-1];
endmodule

// File: rtl/kbd_filter.sv
module kbd_filter #(
  parameter int unsigned PERSIST = 24
) (
  input  logic clk,
  input  logic rst_n,
  input  logic act,
  input  logic masked,
  output logic fire
);
  localparam int unsigned CW = (PERSIST > 1) ? $clog2(PERSIST) : 1;
  localparam logic [CW-1:0] LAST = CW'(PERSIST - 1);

  logic [CW-1:0] cnt_q;
  logic          armed_q;

  assign fire = act && armed_q && !masked && (cnt_q == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      armed_q <= 1'b1;
    end else if (!act) begin
      cnt_q   <= '0;
      armed_q <= 1'b1;
    end else if (masked || !armed_q) begin
      cnt_q <= '0;
    end else if (cnt_q == LAST) begin
      cnt_q   <= '0;
      armed_q <= 1'b0;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  // R4
  fire_after_active_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fire |-> $past(act));

  // R9
  single_fire_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fire |=> !fire);
endmodule

// File: rtl/kbd_regs.sv
module kbd_regs
  import kbd_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic             rd_en,
  input  logic             addr,
  input  logic [7:0]       wdata,
  input  logic [NKEYS-1:0] fire,
  output logic [NKEYS-1:0] level,
  output logic [NKEYS-1:0] mask,
  output logic             wake_en,
  output logic [NKEYS-1:0] flags,
  output logic [7:0]       rdata
);
  logic stat_rd;
  assign stat_rd = rd_en && (addr == ADDR_STAT);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      level   <= '0;
      mask    <= '1;
      wake_en <= 1'b0;
      flags   <= '0;
    end else begin
      if (wr_en && addr == ADDR_CTRL) begin
        level <= wdata[7:4];
        mask  <= wdata[3:0];
      end
      if (wr_en && addr == ADDR_STAT) wake_en <= wdata[WAKE_BIT];
      // a fire in the same cycle as a clearing read survives
      flags <= (stat_rd ? '0 : flags) | fire;
    end
  end

  always_comb begin
    if (addr == ADDR_CTRL) rdata = {level, mask};
    else                   rdata = {3'b000, wake_en, flags};
  end

  // R6
  masked_no_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((flags & ~$past(flags)) & $past(mask)) == '0);

  // R8
  read_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_rd && fire == '0) |=> flags == '0);
endmodule

// File: rtl/kbd_wake_ctrl.sv
module kbd_wake_ctrl
  import kbd_pkg::*;
#(
  parameter int unsigned PERSIST     = 24,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [3:0] key_in,
  input  logic       wr_en,
  input  logic       rd_en,
  input  logic       addr,
  input  logic [7:0] wdata,
  output logic [7:0] rdata,
  output logic       irq,
  output logic       wake
);
  logic [NKEYS-1:0] level, mask, flags, fire, key_s, act_s, act_raw;
  logic             wake_en;

  kbd_sync #(.WIDTH(NKEYS), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .d_in(key_in), .rst_val('1), .d_out(key_s)
  );

  assign act_s   = ~(key_s ^ level);
  assign act_raw = ~(key_in ^ level) & ~mask;

  genvar k;
  generate
    for (k = 0; k < NKEYS; k++) begin : g_col
      kbd_filter #(.PERSIST(PERSIST)) u_filt (
        .clk(clk), .rst_n(rst_n), .act(act_s[k]), .masked(mask[k]), .fire(fire[k])
      );
    end
  endgenerate

  kbd_regs u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .fire(fire), .level(level), .mask(mask), .wake_en(wake_en),
    .flags(flags), .rdata(rdata)
  );

  assign irq  = |(flags & ~mask);
  assign wake = wake_en && (irq || (|act_raw));

  // R10
  wake_needs_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wake |-> wake_en);
endmodule

// File: tb/tb_kbd_wake_ctrl.sv
module tb_kbd_wake_ctrl;
  localparam time CLK_PERIOD = 10ns;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [3:0] key_in = 4'hF;
  logic       wr_en = 1'b0, rd_en = 1'b0, addr = 1'b0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;
  logic       irq, wake;
  int         n_run = 0, n_fail = 0;
  bit         done = 0;

  kbd_wake_ctrl dut (.*);

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(string req, logic [7:0] act, logic [7:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wr(logic a, logic [7:0] d);
    @(negedge clk); addr = a; wdata = d; wr_en = 1'b1;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic rd(logic a, output logic [7:0] d);
    @(negedge clk); addr = a; rd_en = 1'b1; #1 d = rdata;
    @(negedge clk); rd_en = 1'b0;
  endtask

  // key bit idx held at val for exactly n rising edges, then set back to idle
  task automatic pulse(int idx, logic val, logic idle, int n);
    @(negedge clk); key_in[idx] = val;
    repeat (n) @(posedge clk);
    @(negedge clk); key_in[idx] = idle;
    repeat (4) @(negedge clk);
  endtask

  task automatic t_reset();
    logic [7:0] d;
    rd(1'b0, d); check("R1 ctrl", d, 8'h0F);
    rd(1'b1, d); check("R1 stat", d, 8'h00);
    check("R1 irq", {7'd0, irq}, 8'd0);
    check("R1 wake", {7'd0, wake}, 8'd0);
  endtask

  task automatic t_ctrl_rw();
    logic [7:0] d;
    wr(1'b0, 8'hA5); rd(1'b0, d); check("R2 readback", d, 8'hA5);
    wr(1'b1, 8'hFF); rd(1'b1, d); check("R8 stat write only wake bit", d, 8'h10);
    wr(1'b1, 8'h00);
    wr(1'b0, 8'h0E); // col0 unmasked, all low-active
  endtask

  task automatic t_filter_boundary();
    logic [7:0] d;
    pulse(0, 1'b0, 1'b1, 23); rd(1'b1, d); check("R4 23 cycles no flag", d, 8'h00);
    pulse(0, 1'b0, 1'b1, 24);
    check("R7 irq after flag", {7'd0, irq}, 8'd1);
    rd(1'b1, d); check("R4 24 cycles flag / R3 low active", d, 8'h01);
    rd(1'b1, d); check("R8 read cleared", d, 8'h00);
    check("R8 irq cleared", {7'd0, irq}, 8'd0);
  endtask

  task automatic t_latency();
    logic [7:0] d;
    @(negedge clk); key_in[0] = 1'b0;
    repeat (25) @(posedge clk);
    @(negedge clk); addr = 1'b1; #1 d = rdata; check("R4 not yet after 25 edges", d, 8'h00);
    @(posedge clk); @(negedge clk); #1 d = rdata; check("R4 set after 26 edges", d, 8'h01);
    rd(1'b1, d);
    repeat (40) @(negedge clk);
    rd(1'b1, d); check("R9 no reset while held", d, 8'h00);
    @(negedge clk); key_in[0] = 1'b1;
    repeat (3) @(negedge clk);
    pulse(0, 1'b0, 1'b1, 30); rd(1'b1, d); check("R9 re-entry sets", d, 8'h01);
  endtask

  task automatic t_restart();
    logic [7:0] d;
    @(negedge clk); key_in[0] = 1'b0;
    repeat (20) @(negedge clk); key_in[0] = 1'b1;
    @(negedge clk); key_in[0] = 1'b0;
    repeat (20) @(negedge clk); key_in[0] = 1'b1;
    repeat (4) @(negedge clk);
    rd(1'b1, d); check("R5 glitch restarts count", d, 8'h00);
  endtask

  task automatic t_level_mask();
    logic [7:0] d;
    wr(1'b0, 8'h29); // col1 high-active unmasked, col2 low-active unmasked, col0,col3 masked
    pulse(1, 1'b1, 1'b1 ^ 1'b1, 24);
    rd(1'b1, d); check("R3 high-active flag", d, 8'h02);
    key_in[1] = 1'b0;
    wr(1'b0, 8'h2D); // col2 masked too
    pulse(2, 1'b0, 1'b1, 40);
    rd(1'b1, d); check("R6 masked col ignored", d, 8'h00);
    check("R6 no irq", {7'd0, irq}, 8'd0);
    wr(1'b0, 8'h29);
    pulse(2, 1'b0, 1'b1, 24);
    check("R7 irq from col2", {7'd0, irq}, 8'd1);
    wr(1'b0, 8'h2D);
    check("R7 masking drops irq", {7'd0, irq}, 8'd0);
    rd(1'b1, d); check("R7 flag kept under mask", d, 8'h04);
  endtask

  task automatic t_wake();
    wr(1'b0, 8'h29);
    @(negedge clk); key_in[1] = 1'b1; #1;
    check("R10 no wake when disabled", {7'd0, wake}, 8'd0);
    key_in[1] = 1'b0;
    wr(1'b1, 8'h10);
    @(negedge clk); key_in[1] = 1'b1; #1;
    check("R10 raw wake without edge", {7'd0, wake}, 8'd1);
    key_in[1] = 1'b0; #1;
    check("R10 wake drops", {7'd0, wake}, 8'd0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_ctrl_rw();
    t_filter_boundary();
    t_latency();
    t_restart();
    t_level_mask();
    t_wake();
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (100000) @(posedge clk);
        n_run++; n_fail++;
        $display("FAIL watchdog: actual hung expected done");
      end
    join_any
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule